// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Selected Flag Thresholds

This block is a 64-word by 36-bit first-in first-out buffer. It has a write port and a read port, and each port runs on its own free-running clock. The two clocks may be unrelated, or both ports may be driven from one clock. In the shared-clock case a write and a read can be accepted on the same rising edge. A port does something only when its chip select and its enable are both high at a rising edge of its clock. Writes go into a dual-port storage array, and reads deliver words through a registered output.

The write port reports full and almost-full, both registered on the write clock. The read port reports empty and almost-empty, both registered on the read clock. Each side compares its own binary pointer with a copy of the other side's pointer. That copy crosses the clock boundary as a gray code through a two-flop synchroniser. The almost flags use one offset, which a two-bit select input sets while reset is held low. The flags are pessimistic: a port never sees the other side's activity sooner than the synchroniser allows.

Top module: `dcfifo_top`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, with no loss and no duplication. The buffer holds up to 64 words of 36 bits.
- R2: A port acts on a rising edge of its clock only when its chip select and its enable are both 1 at that edge. If either is 0, pointers, flags and data stay as they are.
- R3: A write attempted while full_o is 1 is ignored. Stored words and the write pointer do not change, and a later drain returns the words that were stored before the attempt.
- R4: A read attempted while empty_o is 1 is ignored. rdata_o keeps its previous value.
- R5: rdata_o is registered. After the read-clock edge that accepts a read, it shows the oldest unread word and holds that word until the next accepted read.
- R6: While rst_ni is 0, the block is in its reset state: empty_o=1, almost_empty_o=1, full_o=0, almost_full_o=0, rdata_o=0, and both pointers are zero.
- R7: offset_sel_i is captured while rst_ni is low. The codes map as 2'b00 to 8, 2'b01 to 16, 2'b10 to 4 and 2'b11 to 8.
- R8: almost_empty_o is 1 when the read side's count of stored words is at most the offset. almost_full_o is 1 when the write side's count of free locations is at most the offset.
- R9: With one shared clock, let W[e] and R[e] be the 7-bit write and read pointers after edge e. After edge e, empty_o equals (W[e-3]-R[e]==0), and full_o equals (W[e]-R[e-3]==64). The almost flags use the same counts. A port's own update is seen at once, and the other port's update is seen three edges later.
- R10: The gray-coded pointer that each side sends across the boundary changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| offset_sel_i | input | 2 | Selects the almost-flag offset; captured during reset |
| wcs_i | input | 1 | Write port chip select |
| wen_i | input | 1 | Write enable |
| wdata_i | input | 36 | Write data |
| full_o | output | 1 | No free location (write clock) |
| almost_full_o | output | 1 | Free locations at or below the offset (write clock) |
| rcs_i | input | 1 | Read port chip select |
| ren_i | input | 1 | Read enable |
| rdata_o | output | 36 | Registered read data |
| empty_o | output | 1 | No stored word (read clock) |
| almost_empty_o | output | 1 | Stored words at or below the offset (read clock) |

## Verification
With a shared clock, the bench compares all four flags and the read data against a model of the pointers that keeps three edges of history. This makes an off-by-one in the synchroniser depth, or in either count, show up in the very cycle it occurs. The stimulus runs in several shapes. A write-only fill and a read-only drain separate the behaviour at full from the behaviour at empty. Dense random traffic with partial chip select and enable combinations separates a true two-input qualifier from a single-input one. Each of the four offset codes is exercised so that the decode table is checked. A final run uses unrelated clock periods, where exact cycles cannot be predicted, and there only ordering, integrity and the settled end state are checked.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic [1:0] {
    OFS_SEL_8   = 2'b00,
    OFS_SEL_16  = 2'b01,
    OFS_SEL_4   = 2'b10,
    OFS_SEL_DEF = 2'b11
  } ofs_sel_e;

  localparam int unsigned OFS_VAL_8  = 8;
  localparam int unsigned OFS_VAL_16 = 16;
  localparam int unsigned OFS_VAL_4  = 4;

  function automatic int unsigned ofs_value(input logic [1:0] sel);
    case (ofs_sel_e'(sel))
      OFS_SEL_16: return OFS_VAL_16;
      OFS_SEL_4:  return OFS_VAL_4;
      default:    return OFS_VAL_8;
    endcase
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) ram_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= ram_q[raddr_i];
  end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl #(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic [1:0]        offset_sel_i,
  input  logic              wcs_i,
  input  logic              wen_i,
  input  logic [PTR_W-1:0]  rgray_sync_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [PTR_W-1:0]  wgray_o,
  output logic              full_o,
  output logic              almost_full_o
);
  import dcfifo_pkg::*;

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wbin_q, wbin_d, rbin_s, used_d, free_d, ofs_q;

  assign rbin_s  = g2b(rgray_sync_i);
  assign we_o    = wcs_i & wen_i & ~full_o;
  assign wbin_d  = wbin_q + PTR_W'(we_o);
  assign used_d  = wbin_d - rbin_s;
  assign free_d  = DEPTH_P - used_d;
  assign waddr_o = wbin_q[ADDR_W-1:0];

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q        <= '0;
      wgray_o       <= '0;
      full_o        <= 1'b0;
      almost_full_o <= 1'b0;
      ofs_q         <= PTR_W'(ofs_value(offset_sel_i));
    end else begin
      wbin_q        <= wbin_d;
      wgray_o       <= wbin_d ^ (wbin_d >> 1);
      full_o        <= (used_d == DEPTH_P);
      almost_full_o <= (free_d <= ofs_q);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wcs_i && wen_i && full_o) |=> $stable(wbin_q)) else $error("write accepted when full"); // R3
  AST_WR_QUALIFY: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(wcs_i && wen_i) |=> $stable(wbin_q)) else $error("write without select and enable"); // R2
  AST_WGRAY_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1) else $error("write gray jumps"); // R10
  AST_FULL_IN_AF: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> almost_full_o) else $error("full without almost full"); // R8
  AST_WCOUNT_BOUND: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin_q - rbin_s) <= DEPTH_P) else $error("write count beyond depth"); // R1
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl #(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [1:0]        offset_sel_i,
  input  logic              rcs_i,
  input  logic              ren_i,
  input  logic [PTR_W-1:0]  wgray_sync_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [PTR_W-1:0]  rgray_o,
  output logic              empty_o,
  output logic              almost_empty_o
);
  import dcfifo_pkg::*;

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] rbin_q, rbin_d, wbin_s, avail_d, ofs_q;

  assign wbin_s  = g2b(wgray_sync_i);
  assign re_o    = rcs_i & ren_i & ~empty_o;
  assign rbin_d  = rbin_q + PTR_W'(re_o);
  assign avail_d = wbin_s - rbin_d;
  assign raddr_o = rbin_q[ADDR_W-1:0];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q         <= '0;
      rgray_o        <= '0;
      empty_o        <= 1'b1;
      almost_empty_o <= 1'b1;
      ofs_q          <= PTR_W'(ofs_value(offset_sel_i));
    end else begin
      rbin_q         <= rbin_d;
      rgray_o        <= rbin_d ^ (rbin_d >> 1);
      empty_o        <= (avail_d == '0);
      almost_empty_o <= (avail_d <= ofs_q);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rcs_i && ren_i && empty_o) |=> $stable(rbin_q)) else $error("read accepted when empty"); // R4
  AST_RD_QUALIFY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !(rcs_i && ren_i) |=> $stable(rbin_q)) else $error("read without select and enable"); // R2
  AST_RGRAY_STEP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_o ^ $past(rgray_o)) <= 1) else $error("read gray jumps"); // R10
  AST_EMPTY_IN_AE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> almost_empty_o) else $error("empty without almost empty"); // R8
  AST_RCOUNT_BOUND: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (wbin_s - rbin_q) <= DEPTH_P) else $error("read count beyond depth"); // R1
endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [1:0]        offset_sel_i,
  input  logic              wcs_i,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  output logic              almost_full_o,
  input  logic              rcs_i,
  input  logic              ren_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              almost_empty_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;

  logic              we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;

  dcfifo_wr_ctl #(.ADDR_W(ADDR_W)) i_wr (
    .wclk_i, .rst_ni, .offset_sel_i, .wcs_i, .wen_i,
    .rgray_sync_i(rgray_s), .we_o(we), .waddr_o(waddr), .wgray_o(wgray),
    .full_o, .almost_full_o
  );

  dcfifo_rd_ctl #(.ADDR_W(ADDR_W)) i_rd (
    .rclk_i, .rst_ni, .offset_sel_i, .rcs_i, .ren_i,
    .wgray_sync_i(wgray_s), .re_o(re), .raddr_o(raddr), .rgray_o(rgray),
    .empty_o, .almost_empty_o
  );

  dcfifo_sync #(.WIDTH(PTR_W)) i_w2r (.clk_i(rclk_i), .rst_ni, .d_i(wgray), .q_o(wgray_s));
  dcfifo_sync #(.WIDTH(PTR_W)) i_r2w (.clk_i(wclk_i), .rst_ni, .d_i(rgray), .q_o(rgray_s));

  dcfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
    .wclk_i, .we_i(we), .waddr_i(waddr), .wdata_i,
    .rclk_i, .rst_ni, .re_i(re), .raddr_i(raddr), .rdata_o
  );

  AST_RDATA_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !re |=> $stable(rdata_o)) else $error("read data moved without read"); // R4
endmodule

// File: tb/test_dcfifo_top.sv
`timescale 1ns/1ps
module test_dcfifo_top;
  localparam int DW = 36;
  localparam int PW = 7;
  localparam int DEPTH = 64;

  logic clk_a = 1'b0, clk_b = 1'b0, async_mode = 1'b0;
  logic rclk, rst_ni;
  logic [1:0] offset_sel;
  logic wcs, wen, rcs, ren;
  logic [DW-1:0] wdata, rdata;
  logic full, afull, empty, aempty;

  always #2 clk_a = ~clk_a;
  always #3.3 clk_b = ~clk_b;
  assign rclk = async_mode ? clk_b : clk_a;

  dcfifo_top i_dcfifo_top (
    .wclk_i(clk_a), .rclk_i(rclk), .rst_ni, .offset_sel_i(offset_sel),
    .wcs_i(wcs), .wen_i(wen), .wdata_i(wdata), .full_o(full), .almost_full_o(afull),
    .rcs_i(rcs), .ren_i(ren), .rdata_o(rdata), .empty_o(empty), .almost_empty_o(aempty)
  );

  int n_chk = 0, n_fail = 0;
  logic [PW-1:0] hw [4];
  logic [PW-1:0] hr [4];
  logic [DW-1:0] mem_m [DEPTH];
  logic [DW-1:0] exp_rd;
  int ofs_m;
  logic [DW-1:0] q_m [1024];
  int q_wr, q_rd;

  function automatic int ofs_of(input logic [1:0] s);
    case (s)
      2'b01: return 16;
      2'b10: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom(), $urandom()} & {DW{1'b1}};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic am);
    wcs = 0; wen = 0; rcs = 0; ren = 0; wdata = '0;
    offset_sel = sel;
    rst_ni = 1'b0;
    #1 async_mode = am;
    repeat (3) @(negedge clk_a);
    chk("R6 empty", DW'(empty), DW'(1));
    chk("R6 almost_empty", DW'(aempty), DW'(1));
    chk("R6 full", DW'(full), DW'(0));
    chk("R6 almost_full", DW'(afull), DW'(0));
    chk("R6 rdata", rdata, '0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin hw[i] = '0; hr[i] = '0; end
    exp_rd = '0;
    ofs_m = ofs_of(sel);
    q_wr = 0; q_rd = 0;
  endtask

  // shared clock: exact cycle model
  task automatic shared_run(input int cycles, input int wpct, input int rpct);
    for (int c = 0; c < cycles; c++) begin
      logic [PW-1:0] used_r, used_w;
      logic wtry, rtry, acc_w, acc_r;
      @(negedge clk_a);
      used_r = hw[3] - hr[0];
      used_w = hw[0] - hr[3];
      chk("R9 empty", DW'(empty), DW'(used_r == 0));
      chk("R9 full", DW'(full), DW'(used_w == PW'(DEPTH)));
      chk("R8 R7 almost_empty", DW'(aempty), DW'(int'(used_r) <= ofs_m));
      chk("R8 R7 almost_full", DW'(afull), DW'((DEPTH - int'(used_w)) <= ofs_m));
      chk("R5 R4 R1 rdata", rdata, exp_rd);
      wtry = ($urandom_range(99) < wpct);
      rtry = ($urandom_range(99) < rpct);
      if (wtry) begin wcs = 1; wen = 1; end
      else begin wcs = $urandom_range(1); wen = wcs ? 1'b0 : $urandom_range(1); end
      if (rtry) begin rcs = 1; ren = 1; end
      else begin rcs = $urandom_range(1); ren = rcs ? 1'b0 : $urandom_range(1); end
      wdata = rnd_word();
      acc_w = wtry && !full;     // R2 R3
      acc_r = rtry && !empty;    // R2 R4
      if (acc_w) mem_m[hw[0][5:0]] = wdata;
      if (acc_r) exp_rd = mem_m[hr[0][5:0]];
      for (int i = 3; i > 0; i--) begin hw[i] = hw[i-1]; hr[i] = hr[i-1]; end
      hw[0] = hw[0] + PW'(acc_w);
      hr[0] = hr[0] + PW'(acc_r);
    end
    @(negedge clk_a);
    wcs = 0; wen = 0; rcs = 0; ren = 0;
    for (int i = 3; i > 0; i--) begin hw[i] = hw[i-1]; hr[i] = hr[i-1]; end
  endtask

  // unrelated clocks: order and integrity only
  task automatic async_run(input int nwords);
    fork
      begin : writer
        int sent = 0;
        while (sent < nwords) begin
          @(negedge clk_a);
          wcs = ($urandom_range(99) < 80);
          wen = ($urandom_range(99) < 80);
          wdata = rnd_word();
          if (wcs && wen && !full) begin q_m[q_wr % 1024] = wdata; q_wr++; sent++; end
        end
        @(negedge clk_a); wcs = 0; wen = 0;
      end
      begin : reader
        int got = 0;
        logic pend = 0;
        logic [DW-1:0] exp_w = '0;
        while (got < nwords || pend) begin
          @(negedge clk_b);
          if (pend) begin chk("R1 async order", rdata, exp_w); pend = 0; end
          if (got < nwords) begin
            rcs = ($urandom_range(99) < 70);
            ren = ($urandom_range(99) < 85);
            if (rcs && ren && !empty) begin
              exp_w = q_m[q_rd % 1024]; q_rd++; got++; pend = 1;
            end
          end else begin rcs = 0; ren = 0; end
        end
      end
    join
    repeat (6) @(negedge clk_b);
    chk("R9 async settled empty", DW'(empty), DW'(1));
    chk("R8 async settled almost_empty", DW'(aempty), DW'(1));
    chk("R9 async settled full", DW'(full), DW'(0));
    chk("R8 async settled almost_full", DW'(afull), DW'(0));
  endtask

  logic done = 0;

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_ni = 0;
    // offset 4: fill past full (ignored writes R3), then drain past empty (R4)
    do_reset(2'b10, 1'b0);
    shared_run(80, 100, 0);
    shared_run(80, 0, 100);
    shared_run(600, 50, 50);
    // offset 16
    do_reset(2'b01, 1'b0);
    shared_run(600, 70, 30);
    shared_run(200, 20, 80);
    // offset 8, code 3
    do_reset(2'b11, 1'b0);
    shared_run(70, 100, 0);
    shared_run(70, 0, 100);
    // offset 8, code 0, dense traffic including same-edge read and write
    do_reset(2'b00, 1'b0);
    shared_run(800, 90, 90);
    shared_run(80, 0, 100);
    // unrelated clocks
    do_reset(2'b00, 1'b1);
    async_run(600);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule